// File: doc/BRIEF.md
# Timer Clock and Gate Router

This block sits between three 16-bit timers and the pins around them. For each timer it picks a clock input and a gate (enable) input from a small set of candidates. The candidates are a 4 MHz oscillator, a few external pins, a constant "always enabled" level, or the output of a neighbouring timer. Taking a neighbour's output lets timers be chained into one long divider. The timers are outside the block: their clock and gate inputs leave through `tmrClk` and `tmrGate`, and their outputs come back on `tmrOut`.

Two byte-wide registers hold all choices. The clock-select register sits at offset 0xE and the gate-select register at offset 0xF. Both can be written and read back over a simple synchronous bus. One bit of the clock-select register turns the three timer outputs onto three shared pins. Three more bits carry per-timer trigger polarity out to the interrupt logic. The clock and gate paths are plain combinational multiplexers, with no glitch-free switching.

Pin naming used below: `sharedPinIn[2:0]` are the input buffers of the three pins that the timer outputs can drive. `sidePin[3:0]` are four input-only pins.

Top module: `tmr_route_top`

## Requirements
- R1: After reset both registers read 0x00, every timer clock follows `oscClk`, every gate is 1, `sharedPinOe` is 3'b000 and `trigPol` is 3'b000.
- R2: A write with `busWrEn` high at offset 0xE or 0xF stores all 8 data bits at the clock edge. From the next cycle a read at that offset returns the stored byte, and the routing reflects it.
- R3: A write at any other offset changes neither register, and a read at any other offset returns 0x00.
- R4: Timer 0 clock uses clock-select bits [1:0]: 0 is `oscClk`, 1 is `sharedPinIn[0]`, 2 is `tmrOut[2]`, 3 is `sidePin[0]`. A change of source shows on `tmrClk[0]` in the same cycle, with no register delay.
- R5: Timer 1 clock uses clock-select bits [3:2]: 0 is `oscClk`, 1 is `sharedPinIn[1]`, 2 is `tmrOut[0]`, 3 is `sidePin[1]`.
- R6: Timer 2 clock uses clock-select bits [5:4]: 0 is `oscClk`, 1 is `sharedPinIn[2]`, 2 is `tmrOut[1]`, 3 is `sidePin[2]`.
- R7: Gates use gate-select bits [1:0], [3:2] and [5:4] for timers 0, 1 and 2. Code 0 is a constant 1 for every timer. For timer 0, codes 1, 2 and 3 are `sharedPinIn[2]`, `sidePin[0]` and `sidePin[1]`. For timer 1 they are `sharedPinIn[0]`, `sidePin[1]` and `sidePin[2]`. For timer 2 they are `sharedPinIn[1]`, `sidePin[2]` and `sidePin[3]`.
- R8: When clock-select bit 7 is 1, `sharedPinOe` is 3'b111 and `sharedPinOut` is {`tmrOut[1]`, `tmrOut[0]`, `tmrOut[2]`}. When that bit is 0, `sharedPinOe` and `sharedPinOut` are 3'b000.
- R9: Routing from a shared pin always uses `sharedPinIn`, whatever the output enable is. A timer output driven onto that pin does not replace the pin input inside the block.
- R10: `trigPol` is {gate-select bit 7, gate-select bit 6, clock-select bit 6}, which are the polarities of timers 2, 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Register offset |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for `busAddr` (combinational) |
| oscClk | input | 1 | 4 MHz oscillator source |
| tmrOut | input | 3 | Outputs of timers 0..2 |
| sharedPinIn | input | 3 | Input buffers of the three drivable pins |
| sidePin | input | 4 | Input-only pins |
| tmrClk | output | 3 | Selected clock for timers 0..2 |
| tmrGate | output | 3 | Selected gate for timers 0..2 |
| sharedPinOut | output | 3 | Timer outputs routed to the shared pins |
| sharedPinOe | output | 3 | Output enables of the shared pins |
| trigPol | output | 3 | Trigger polarity per timer |

## Verification
Two functions can fall in the same cycle: enabling the output drive and routing a timer clock from the very pin being driven. The bench provokes this with one clock-select write that sets bit 7 and picks the shared pin as timer 1's clock. It then drives `tmrOut[0]` and `sharedPinIn[1]` to opposite values. The result is judged right only if `sharedPinOut[1]` follows the timer while `tmrClk[1]` follows the pin input. A second overlap, a register write changing a source while the old source is moving, is judged by checking the routed output at the first sample after the write edge.

// File: rtl/tmr_route_pkg.sv
package tmr_route_pkg;

  localparam int NUM_TMR = 3;
  localparam int REG_W   = 8;
  localparam int SEL_W   = 2;

  // Flat source vector layout
  localparam int SRC_OSC  = 0;
  localparam int SRC_ONE  = 1;
  localparam int SRC_TMR  = 2;
  localparam int SRC_SHR  = SRC_TMR + NUM_TMR;
  localparam int SRC_SIDE = SRC_SHR + NUM_TMR;
  localparam int SIDE_CNT = 4;
  localparam int SRC_CNT  = SRC_SIDE + SIDE_CNT;

  localparam int DRV_BIT  = 7;
  localparam int POL0_BIT = 6;

  typedef struct packed {
    logic             wrClkReg;
    logic             wrGateReg;
    logic [REG_W-1:0] data;
  } regStrobeT;

  // Clock source index per timer and select code
  function automatic int clkSrcIdx(input int t, input int code);
    int idx;
    case (code)
      0: idx = SRC_OSC;
      1: idx = SRC_SHR + t;
      2: idx = SRC_TMR + ((t + NUM_TMR - 1) % NUM_TMR);
      default: idx = SRC_SIDE + t;
    endcase
    return idx;
  endfunction

  // Gate source index per timer and select code
  function automatic int gateSrcIdx(input int t, input int code);
    int idx;
    case (code)
      0: idx = SRC_ONE;
      1: idx = SRC_SHR + ((t + NUM_TMR - 1) % NUM_TMR);
      2: idx = SRC_SIDE + t;
      default: idx = SRC_SIDE + t + 1;
    endcase
    return idx;
  endfunction

  // Which timer drives shared pin p
  function automatic int drvTmrIdx(input int p);
    return (p + NUM_TMR - 1) % NUM_TMR;
  endfunction

endpackage

// File: rtl/tmr_route_ctrl.sv
module tmr_route_ctrl
  import tmr_route_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int CLK_REG_OFS  = 'hE,
  parameter int GATE_REG_OFS = 'hF
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [REG_W-1:0]  busWrData,
  input  logic [REG_W-1:0]  clkReg,
  input  logic [REG_W-1:0]  gateReg,
  output regStrobeT         strb,
  output logic [REG_W-1:0]  busRdData
);

  localparam logic [ADDR_W-1:0] CLK_ADDR  = ADDR_W'(CLK_REG_OFS);
  localparam logic [ADDR_W-1:0] GATE_ADDR = ADDR_W'(GATE_REG_OFS);

  logic hitClk;
  logic hitGate;

  assign hitClk  = (busAddr == CLK_ADDR);
  assign hitGate = (busAddr == GATE_ADDR);

  always_comb begin
    strb.wrClkReg  = busWrEn && hitClk;
    strb.wrGateReg = busWrEn && hitGate;
    strb.data      = busWrData;
  end

  always_comb begin
    busRdData = '0;
    if (hitClk)       busRdData = clkReg;
    else if (hitGate) busRdData = gateReg;
  end

endmodule

// File: rtl/tmr_route_regs.sv
module tmr_route_regs
  import tmr_route_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  regStrobeT        strb,
  output logic [REG_W-1:0] clkReg,
  output logic [REG_W-1:0] gateReg
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkReg  <= '0;
      gateReg <= '0;
    end else begin
      if (strb.wrClkReg)  clkReg  <= strb.data;
      if (strb.wrGateReg) gateReg <= strb.data;
    end
  end

  AST_CLKREG_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrClkReg |=> (clkReg == $past(strb.data))); // R2
  AST_GATEREG_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrGateReg |=> (gateReg == $past(strb.data))); // R2
  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrClkReg && !strb.wrGateReg) |=> ($stable(clkReg) && $stable(gateReg))); // R3

endmodule

// File: rtl/tmr_route_mux.sv
module tmr_route_mux
  import tmr_route_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [REG_W-1:0]   clkReg,
  input  logic [REG_W-1:0]   gateReg,
  input  logic               oscClk,
  input  logic [NUM_TMR-1:0] tmrOut,
  input  logic [NUM_TMR-1:0] sharedPinIn,
  input  logic [SIDE_CNT-1:0] sidePin,
  output logic [NUM_TMR-1:0] tmrClk,
  output logic [NUM_TMR-1:0] tmrGate,
  output logic [NUM_TMR-1:0] sharedPinOut,
  output logic [NUM_TMR-1:0] sharedPinOe,
  output logic [NUM_TMR-1:0] trigPol
);

  logic [SRC_CNT-1:0] srcVec;
  logic               drvEn;

  assign srcVec = {sidePin, sharedPinIn, tmrOut, 1'b1, oscClk};
  assign drvEn  = clkReg[DRV_BIT];

  for (genvar t = 0; t < NUM_TMR; t++) begin : gTmr
    localparam int C0 = clkSrcIdx(t, 0);
    localparam int C1 = clkSrcIdx(t, 1);
    localparam int C2 = clkSrcIdx(t, 2);
    localparam int C3 = clkSrcIdx(t, 3);
    localparam int G0 = gateSrcIdx(t, 0);
    localparam int G1 = gateSrcIdx(t, 1);
    localparam int G2 = gateSrcIdx(t, 2);
    localparam int G3 = gateSrcIdx(t, 3);

    logic [SEL_W-1:0] cSel;
    logic [SEL_W-1:0] gSel;
    logic             clkBit;
    logic             gateBit;

    assign cSel = clkReg[SEL_W*t +: SEL_W];
    assign gSel = gateReg[SEL_W*t +: SEL_W];

    always_comb begin
      case (cSel)
        2'd0:    clkBit = srcVec[C0];
        2'd1:    clkBit = srcVec[C1];
        2'd2:    clkBit = srcVec[C2];
        default: clkBit = srcVec[C3];
      endcase
    end

    always_comb begin
      case (gSel)
        2'd0:    gateBit = srcVec[G0];
        2'd1:    gateBit = srcVec[G1];
        2'd2:    gateBit = srcVec[G2];
        default: gateBit = srcVec[G3];
      endcase
    end

    assign tmrClk[t]  = clkBit;
    assign tmrGate[t] = gateBit;

    localparam int DRV_T = drvTmrIdx(t);
    assign sharedPinOut[t] = drvEn & tmrOut[DRV_T];
    assign sharedPinOe[t]  = drvEn;
  end

  assign trigPol = {gateReg[POL0_BIT+1], gateReg[POL0_BIT], clkReg[POL0_BIT]};

  AST_OE_ALL_OR_NONE: assert property (@(posedge clk) disable iff (!rstN)
    (sharedPinOe == '0) || (sharedPinOe == '1)); // R8
  AST_DRIVE_MAP: assert property (@(posedge clk) disable iff (!rstN)
    (&sharedPinOe) |-> (sharedPinOut == {tmrOut[1], tmrOut[0], tmrOut[2]})); // R8
  AST_GATE0_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (gateReg[1:0] == 2'd0) |-> tmrGate[0]); // R7
  AST_CASCADE_T1: assert property (@(posedge clk) disable iff (!rstN)
    (clkReg[3:2] == 2'd2) |-> (tmrClk[1] == tmrOut[0])); // R5
  AST_PIN_INPUT_T1: assert property (@(posedge clk) disable iff (!rstN)
    (clkReg[3:2] == 2'd1) |-> (tmrClk[1] == sharedPinIn[1])); // R9

endmodule

// File: rtl/tmr_route_top.sv
module tmr_route_top
  import tmr_route_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int CLK_REG_OFS  = 'hE,
  parameter int GATE_REG_OFS = 'hF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  input  logic              oscClk,
  input  logic [2:0]        tmrOut,
  input  logic [2:0]        sharedPinIn,
  input  logic [3:0]        sidePin,
  output logic [2:0]        tmrClk,
  output logic [2:0]        tmrGate,
  output logic [2:0]        sharedPinOut,
  output logic [2:0]        sharedPinOe,
  output logic [2:0]        trigPol
);

  regStrobeT        strb;
  logic [REG_W-1:0] clkReg;
  logic [REG_W-1:0] gateReg;

  tmr_route_ctrl #(
    .ADDR_W(ADDR_W), .CLK_REG_OFS(CLK_REG_OFS), .GATE_REG_OFS(GATE_REG_OFS)
  ) uCtrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .clkReg(clkReg), .gateReg(gateReg), .strb(strb), .busRdData(busRdData)
  );

  tmr_route_regs uRegs (
    .clk(clk), .rstN(rstN), .strb(strb), .clkReg(clkReg), .gateReg(gateReg)
  );

  tmr_route_mux uMux (
    .clk(clk), .rstN(rstN), .clkReg(clkReg), .gateReg(gateReg),
    .oscClk(oscClk), .tmrOut(tmrOut), .sharedPinIn(sharedPinIn), .sidePin(sidePin),
    .tmrClk(tmrClk), .tmrGate(tmrGate), .sharedPinOut(sharedPinOut),
    .sharedPinOe(sharedPinOe), .trigPol(trigPol)
  );

endmodule

// File: tb/tmr_route_top_test.sv
`timescale 1ns/1ps
module tmr_route_top_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] busAddr = 4'h0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic       oscClk = 1'b0;
  logic [2:0] tmrOut = 3'b000;
  logic [2:0] sharedPinIn = 3'b000;
  logic [3:0] sidePin = 4'b0000;
  logic [2:0] tmrClk, tmrGate, sharedPinOut, sharedPinOe, trigPol;

  int total = 0;
  int failed = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_route_top uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .oscClk(oscClk),
    .tmrOut(tmrOut), .sharedPinIn(sharedPinIn), .sidePin(sidePin),
    .tmrClk(tmrClk), .tmrGate(tmrGate), .sharedPinOut(sharedPinOut),
    .sharedPinOe(sharedPinOe), .trigPol(trigPol)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busAddr = 4'h0;
    #1;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [7:0] d);
    busAddr = a;
    #1;
    d = busRdData;
    busAddr = 4'h0;
  endtask

  // {side[3:0], shared[2:0], tmr[2:0], osc}
  task automatic applySrc(input logic [10:0] v);
    oscClk = v[0]; tmrOut = v[3:1]; sharedPinIn = v[6:4]; sidePin = v[10:7];
    #1;
  endtask

  function automatic logic expClk(input int t, input int code);
    case (code)
      0: return oscClk;
      1: return sharedPinIn[t];
      2: return (t == 0) ? tmrOut[2] : (t == 1) ? tmrOut[0] : tmrOut[1];
      default: return sidePin[t];
    endcase
  endfunction

  function automatic logic expGate(input int t, input int code);
    if (code == 0) return 1'b1;
    case (t)
      0: return (code == 1) ? sharedPinIn[2] : (code == 2) ? sidePin[0] : sidePin[1];
      1: return (code == 1) ? sharedPinIn[0] : (code == 2) ? sidePin[1] : sidePin[2];
      default: return (code == 1) ? sharedPinIn[1] : (code == 2) ? sidePin[2] : sidePin[3];
    endcase
  endfunction

  task automatic testReset;
    logic [7:0] d;
    busRead(4'hE, d); check("R1 clk reg", d, 8'h00);
    busRead(4'hF, d); check("R1 gate reg", d, 8'h00);
    applySrc(11'h7FF); check("R1 clk osc high", tmrClk, 3'b111);
    applySrc(11'h7FE); check("R1 clk osc low", tmrClk, 3'b000);
    applySrc(11'h000); check("R1 gates open", tmrGate, 3'b111);
    check("R1 oe", sharedPinOe, 3'b000);
    check("R1 pol", trigPol, 3'b000);
  endtask

  task automatic testRegAccess;
    logic [7:0] d;
    busWrite(4'hE, 8'h5A); busRead(4'hE, d); check("R2 clk reg readback", d, 8'h5A);
    busWrite(4'hF, 8'hC3); busRead(4'hF, d); check("R2 gate reg readback", d, 8'hC3);
    busWrite(4'hE, 8'h00); busWrite(4'hF, 8'h00);
  endtask

  task automatic testOtherAddr;
    logic [7:0] d;
    busWrite(4'hE, 8'h3C); busWrite(4'hF, 8'h25);
    busWrite(4'h3, 8'hFF); busWrite(4'hD, 8'hAA); busWrite(4'h0, 8'h11);
    busRead(4'hE, d); check("R3 clk reg kept", d, 8'h3C);
    busRead(4'hF, d); check("R3 gate reg kept", d, 8'h25);
    busRead(4'h3, d); check("R3 other reads zero", d, 8'h00);
    busRead(4'hD, d); check("R3 other reads zero D", d, 8'h00);
    busWrite(4'hE, 8'h00); busWrite(4'hF, 8'h00);
  endtask

  task automatic testClockRoutes;
    string reqName[3] = '{"R4", "R5", "R6"};
    for (int code = 0; code < 4; code++) begin
      busWrite(4'hE, 8'(code * 8'h15));
      for (int k = 0; k < 6; k++) begin
        applySrc(11'(11'h4C6 ^ (k * 11'h35B)));
        for (int t = 0; t < 3; t++)
          check(reqName[t], {15'd0, tmrClk[t]}, {15'd0, expClk(t, code)});
      end
    end
    // R4 same-cycle: source change visible without a clock edge
    busWrite(4'hE, 8'h02);
    @(negedge clk); tmrOut[2] = 1'b1; #0.5;
    check("R4 same-cycle cascade", {15'd0, tmrClk[0]}, 16'd1);
    tmrOut[2] = 1'b0; #0.5;
    check("R4 same-cycle cascade low", {15'd0, tmrClk[0]}, 16'd0);
    busWrite(4'hE, 8'h00);
  endtask

  task automatic testGateRoutes;
    for (int code = 0; code < 4; code++) begin
      busWrite(4'hF, 8'(code * 8'h15));
      for (int k = 0; k < 6; k++) begin
        applySrc(11'(11'h2B9 ^ (k * 11'h1E7)));
        for (int t = 0; t < 3; t++)
          check("R7 gate route", {15'd0, tmrGate[t]}, {15'd0, expGate(t, code)});
      end
    end
    busWrite(4'hF, 8'h00);
  endtask

  task automatic testDrive;
    busWrite(4'hE, 8'h80);
    for (int v = 0; v < 8; v++) begin
      tmrOut = 3'(v); #1;
      check("R8 oe on", sharedPinOe, 3'b111);
      check("R8 drive map", sharedPinOut, {tmrOut[1], tmrOut[0], tmrOut[2]});
    end
    busWrite(4'hE, 8'h00);
    tmrOut = 3'b111; #1;
    check("R8 oe off", sharedPinOe, 3'b000);
    check("R8 out off", sharedPinOut, 3'b000);
  endtask

  task automatic testPinInput;
    // drive enable and timer1 clock from shared pin 1, set in one write
    busWrite(4'hE, 8'h84);
    tmrOut = 3'b001; sharedPinIn = 3'b000; #1;
    check("R9 drives timer0", {15'd0, sharedPinOut[1]}, 16'd1);
    check("R9 clk from pin input", {15'd0, tmrClk[1]}, 16'd0);
    tmrOut = 3'b000; sharedPinIn = 3'b010; #1;
    check("R9 clk from pin input high", {15'd0, tmrClk[1]}, 16'd1);
    busWrite(4'hE, 8'h00);
  endtask

  task automatic testPolarity;
    busWrite(4'hE, 8'h40); check("R10 pol0", trigPol, 3'b001);
    busWrite(4'hF, 8'h40); check("R10 pol1", trigPol, 3'b011);
    busWrite(4'hF, 8'h80); check("R10 pol2", trigPol, 3'b101);
    busWrite(4'hE, 8'h00); busWrite(4'hF, 8'hC0); check("R10 pol12", trigPol, 3'b110);
    busWrite(4'hF, 8'h00);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - failed, total);
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    testReset();
    rstN = 1'b1;
    testRegAccess();
    testOtherAddr();
    testClockRoutes();
    testGateRoutes();
    testDrive();
    testPinInput();
    testPolarity();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule